// File: doc/BRIEF.md
# Reader Power-Up Configuration Sequencer

This block takes a contactless reader core from reset to a ready state. Once reset is released it sits in a start-up phase and waits for the oscillator to report a stable clock. After that it opens an initialization window of exactly 128 cycles. In that window it copies 32 configuration bytes from two 16-byte non-volatile blocks into the register file, at register addresses 10h to 2Fh. When the window closes it moves to idle without outside help.

The 6-bit command value also shows which phase the block is in. It reads 00h while the block waits for the oscillator, 3Fh throughout initialization, and 00h again at idle. A host can load the command value only at idle, and only while that value is still zero. The non-volatile memory is reached through a synchronous read port that returns data one cycle after the request.

Top module: `rdr_pwrup_seq`

## Requirements
- R1: While `rst_n` is low, `cmd` is 00h, `busy` is 1, and both `nv_rd_en` and `reg_wr_en` are 0.
- R2: After reset is released, and for as long as `osc_ok` is sampled low, the block stays in start-up with `cmd` at 00h and `busy` at 1. Host command writes have no effect in this phase.
- R3: In start-up, the clock edge that samples `osc_ok` high starts initialization, and `cmd` reads 3Fh in the cycle that follows.
- R4: Initialization lasts exactly 128 cycles, with `cmd` at 3Fh and `busy` at 1 in every one of them. After that, `cmd` is 00h and `busy` is 0.
- R5: In the first 32 cycles of initialization (index i = 0..31), `nv_rd_en` is 1 and `nv_addr` equals i. Bit 4 of `nv_addr` selects the block: 0 is the first block and 1 is the second. In all other cycles `nv_rd_en` is 0.
- R6: One cycle after each read at index i, `reg_wr_en` is 1, `reg_wr_addr` is 10h+i and `reg_wr_data` is the byte returned by the read. This gives exactly 32 writes in ascending address order, covering 10h to 2Fh.
- R7: At idle, a host write loads `host_cmd_wdata` into `cmd` on the next edge, but only if `cmd` is 00h. While `cmd` is non-zero, host writes are ignored.
- R8: Asserting reset during initialization stops the copy, and no further register writes occur. Once reset is released the block is back in start-up, and a later initialization performs the full 32-byte copy again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_ok | input | 1 | Oscillator-stable indication |
| host_cmd_we | input | 1 | Host write strobe for the command value |
| host_cmd_wdata | input | 6 | Host command write data |
| cmd | output | 6 | Command value / phase indicator |
| busy | output | 1 | High in start-up and initialization |
| nv_rd_en | output | 1 | Non-volatile read request |
| nv_addr | output | 5 | Non-volatile byte address (bit 4 selects the block) |
| nv_rd_data | input | 8 | Read data, valid one cycle after the request |
| reg_wr_en | output | 1 | Register-file write strobe |
| reg_wr_addr | output | 6 | Register-file write address |
| reg_wr_data | output | 8 | Register-file write data |

## Verification
A change of `osc_ok` or of a host write shows up on `cmd` one edge later. Each read appears in the same cycle as its initialization index, and the matching register write follows exactly one cycle after the read. The bench drives inputs and samples outputs at falling edges and counts initialization indices from the first sample that shows 3Fh. Against that count it checks that every read falls on its own index and every write on the index after it, and that exactly 128 samples show 3Fh before `busy` drops.

// File: rtl/rdr_pwrup_seq.sv
module rdr_pwrup_seq #(
  parameter int DATA_W      = 8,
  parameter int BLK_BYTES   = 16,
  parameter int INIT_CYCLES = 128,
  parameter int REG_AW      = 6,
  parameter int CMD_W       = 6,
  parameter logic [REG_AW-1:0] BASE_ADDR   = 6'h10,
  parameter logic [CMD_W-1:0]  ACTIVE_CODE = 6'h3F,
  localparam int NBYTES = 2 * BLK_BYTES,
  localparam int NV_AW  = $clog2(NBYTES),
  localparam int CNT_W  = $clog2(INIT_CYCLES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_ok,
  input  logic              host_cmd_we,
  input  logic [CMD_W-1:0]  host_cmd_wdata,
  output logic [CMD_W-1:0]  cmd,
  output logic              busy,
  output logic              nv_rd_en,
  output logic [NV_AW-1:0]  nv_addr,
  input  logic [DATA_W-1:0] nv_rd_data,
  output logic              reg_wr_en,
  output logic [REG_AW-1:0] reg_wr_addr,
  output logic [DATA_W-1:0] reg_wr_data
);

  typedef enum logic [1:0] {PH_START, PH_INIT, PH_IDLE} phase_t;

  phase_t             ph;
  logic [CNT_W-1:0]   cnt;
  logic [CMD_W-1:0]   cmd_q;
  logic               wr_q;
  logic [REG_AW-1:0]  wa_q;

  wire last_cyc = cnt == CNT_W'(INIT_CYCLES - 1);

  assign nv_rd_en    = (ph == PH_INIT) && (cnt < CNT_W'(NBYTES));
  assign nv_addr     = cnt[NV_AW-1:0];
  assign busy        = ph != PH_IDLE;
  assign cmd         = cmd_q;
  assign reg_wr_en   = wr_q;
  assign reg_wr_addr = wa_q;
  assign reg_wr_data = nv_rd_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= PH_START;
      cnt   <= '0;
      cmd_q <= '0;
      wr_q  <= 1'b0;
      wa_q  <= '0;
    end else begin
      wr_q <= nv_rd_en;
      wa_q <= BASE_ADDR + REG_AW'(cnt[NV_AW-1:0]);
      case (ph)
        PH_START: if (osc_ok) begin
          ph    <= PH_INIT;
          cnt   <= '0;
          cmd_q <= ACTIVE_CODE;
        end
        PH_INIT: begin
          cnt <= cnt + 1'b1;
          if (last_cyc) begin
            ph    <= PH_IDLE;
            cmd_q <= '0;
          end
        end
        default: if (host_cmd_we && cmd_q == '0) cmd_q <= host_cmd_wdata;
      endcase
    end
  end

endmodule

// File: rtl/rdr_pwrup_seq_chk.sv
module rdr_pwrup_seq_chk #(
  parameter int INIT_CYCLES = 128,
  parameter int CMD_W       = 6,
  parameter int NV_AW       = 5,
  parameter int REG_AW      = 6,
  parameter logic [CMD_W-1:0] ACTIVE_CODE = 6'h3F
) (
  input logic              clk,
  input logic              rst_n,
  input logic              osc_ok,
  input logic              host_cmd_we,
  input logic [CMD_W-1:0]  cmd,
  input logic              busy,
  input logic              nv_rd_en,
  input logic [NV_AW-1:0]  nv_addr,
  input logic              reg_wr_en,
  input logic [REG_AW-1:0] reg_wr_addr
);

  logic [15:0] win;
  always_ff @(posedge clk) begin
    if (!rst_n) win <= '0;
    else if (busy && cmd != '0) win <= win + 1'b1;
    else win <= '0;
  end

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (cmd == '0 && busy && !reg_wr_en));

  a_r2_startup_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd == '0 && !osc_ok) |=> (busy && cmd == '0));

  a_r3_enter_init: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd == '0 && osc_ok) |=> (cmd == ACTIVE_CODE));

  a_r4_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd != '0) |-> (win < 16'(INIT_CYCLES)));

  a_r4_window_end: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd != '0 && win == 16'(INIT_CYCLES - 1)) |=> (!busy && cmd == '0));

  a_r5_read_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    nv_rd_en |-> (busy && cmd == ACTIVE_CODE));

  a_r6_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> $past(nv_rd_en));

  a_r6_write_addr: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> (reg_wr_addr == REG_AW'(6'h10) + REG_AW'($past(nv_addr))));

  a_r7_hold_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd != '0) |=> $stable(cmd));

  a_r7_idle_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd == '0 && !host_cmd_we) |=> (cmd == '0));

endmodule

bind rdr_pwrup_seq rdr_pwrup_seq_chk #(
  .INIT_CYCLES(INIT_CYCLES), .CMD_W(CMD_W), .NV_AW(NV_AW),
  .REG_AW(REG_AW), .ACTIVE_CODE(ACTIVE_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .osc_ok(osc_ok), .host_cmd_we(host_cmd_we),
  .cmd(cmd), .busy(busy), .nv_rd_en(nv_rd_en), .nv_addr(nv_addr),
  .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr)
);

// File: tb/tb_rdr_pwrup_seq.sv
module tb_rdr_pwrup_seq;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0, osc_ok = 1'b0, host_cmd_we = 1'b0;
  logic [5:0] host_cmd_wdata = '0, cmd;
  logic       busy, nv_rd_en, reg_wr_en;
  logic [4:0] nv_addr;
  logic [7:0] nv_rd_data = '0, reg_wr_data;
  logic [5:0] reg_wr_addr;

  rdr_pwrup_seq dut (.*);

  logic [7:0] mem [32];
  logic [7:0] regs [64];
  int checks = 0, fails = 0;
  bit done = 0;

  always @(posedge clk) if (nv_rd_en) nv_rd_data <= mem[nv_addr];
  always @(posedge clk) if (rst_n && reg_wr_en) regs[reg_wr_addr] <= reg_wr_data;

  function automatic int exp_addr(int i);
    return 16 + i;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill_mem();
    for (int i = 0; i < 32; i++) mem[i] = 8'($urandom);
    for (int i = 0; i < 64; i++) regs[i] = 8'h00;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; osc_ok = 1'b0; host_cmd_we = 1'b0;
    repeat (3) @(negedge clk);
    chk(cmd == 6'h00 && busy && !nv_rd_en && !reg_wr_en, "R1 reset state",
        {cmd, busy, nv_rd_en, reg_wr_en}, {6'h00, 3'b100});
    rst_n = 1'b1;
  endtask

  task automatic startup_hold(int n);
    int bad = 0;
    for (int k = 0; k < n; k++) begin
      host_cmd_we = 1'($urandom); host_cmd_wdata = 6'($urandom);
      @(negedge clk);
      if (cmd != 6'h00 || !busy || nv_rd_en || reg_wr_en) bad++;
    end
    host_cmd_we = 1'b0;
    chk(bad == 0, "R2 start-up hold", bad, 0);
  endtask

  task automatic full_init(string tag);
    int idx = 0, nact = 0, nw = 0, bad_rd = 0, bad_wr = 0;
    bit first = 1;
    osc_ok = 1'b1;
    chk(cmd == 6'h00, "R3 before edge", cmd, 0);
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (first) begin
        chk(cmd == 6'h3F && busy, "R3 init entry", cmd, 6'h3F);
        first = 0;
      end
      if (!busy) break;
      if (cmd == 6'h3F) nact++;
      if (nv_rd_en != (idx < 32) || (idx < 32 && nv_addr != 5'(idx))) bad_rd++;
      if (reg_wr_en) begin
        if (idx != nw + 1 || reg_wr_addr != 6'(exp_addr(nw)) || reg_wr_data != mem[nw]) bad_wr++;
        nw++;
      end
      idx++;
      host_cmd_we = 1'($urandom); host_cmd_wdata = 6'($urandom);
    end
    host_cmd_we = 1'b0;
    chk(nact == 128, {"R4 window length ", tag}, nact, 128);
    chk(cmd == 6'h00 && !busy, {"R4 idle after window ", tag}, cmd, 0);
    chk(bad_rd == 0, {"R5 read schedule ", tag}, bad_rd, 0);
    chk(nw == 32, {"R6 write count ", tag}, nw, 32);
    chk(bad_wr == 0, {"R6 write addr/data/timing ", tag}, bad_wr, 0);
    begin
      int mis = 0;
      for (int i = 0; i < 32; i++) if (regs[exp_addr(i)] != mem[i]) mis++;
      chk(mis == 0, {"R6 register contents ", tag}, mis, 0);
    end
  endtask

  initial begin
    int unused_seed = $urandom(32'd20240611);
    int exp_cmd, bad;
    fill_mem();
    do_reset();
    startup_hold(10 + int'($urandom % 30));
    full_init("first");

    // R7 directed: load at zero, then ignore
    host_cmd_we = 1'b1; host_cmd_wdata = 6'h05;
    @(negedge clk);
    host_cmd_we = 1'b0;
    chk(cmd == 6'h05, "R7 idle load", cmd, 5);
    host_cmd_we = 1'b1; host_cmd_wdata = 6'h09;
    @(negedge clk);
    host_cmd_we = 1'b0;
    chk(cmd == 6'h05, "R7 nonzero ignore", cmd, 5);

    do_reset();
    chk(cmd == 6'h00, "R1 cmd cleared", cmd, 0);
    startup_hold(5);
    fill_mem();
    full_init("second");

    // R7 random idle writes against a model
    exp_cmd = 0; bad = 0;
    for (int k = 0; k < 40; k++) begin
      host_cmd_we = 1'($urandom % 4 == 0);
      host_cmd_wdata = (k < 20) ? 6'h00 : 6'($urandom);
      if (host_cmd_we && exp_cmd == 0) exp_cmd = host_cmd_wdata;
      @(negedge clk);
      if (cmd != 6'(exp_cmd)) bad++;
    end
    host_cmd_we = 1'b0;
    chk(bad == 0, "R7 random idle writes", bad, 0);

    // R8 reset during initialization
    begin
      int k = 5 + int'($urandom % 20), nw = 0;
      do_reset();
      fill_mem();
      osc_ok = 1'b1;
      for (int j = 0; j < k; j++) begin
        @(negedge clk);
        if (reg_wr_en) nw++;
      end
      chk(nw == k - 1, "R8 partial writes before abort", nw, k - 1);
      do_reset();
      nw = 0; bad = 0;
      for (int j = 0; j < 8; j++) begin
        @(negedge clk);
        if (reg_wr_en || nv_rd_en) nw++;
        if (cmd != 6'h00 || !busy) bad++;
      end
      chk(nw == 0, "R8 no writes after abort", nw, 0);
      chk(bad == 0, "R8 back in start-up", bad, 0);
      fill_mem();
      full_init("after abort R8");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule